// File: doc/BRIEF.md
# Memory Power-Down State Controller

This block follows the power state of a graphics DRAM device. It watches the clock-enable input, the open or closed status of each bank, and the decoded command strobes. From these it decides whether the device is running normally, is in precharge power-down (clock enable low, every bank closed), is in active power-down (clock enable low, at least one bank open), or is in self refresh. It drives two enables: one for the command, address and data input receivers, and one for the differential clock receivers. It also raises an error pulse when clock enable is pulled low while data is moving.

Clock enable arrives on two pins. `cke_reg` is a copy already registered in the clock domain. `cke_raw` is an unclocked copy. Ordinary power-down ends on a rising edge that samples `cke_reg` high. Self refresh ends as soon as `cke_raw` rises: the clock receiver enable follows `cke_raw` at once, with no edge involved. The state register catches up after `cke_raw` has passed through a synchronizer. The block keeps its own mask of open banks, updated from activate and precharge commands.

Top module: `dram_pwr_state_ctrl`

## Requirements
- R1: With `rst` high at a rising edge, the block returns to normal state. `pd_state` reads 0, `open_banks` reads 0, `in_rx_en` and `clk_rx_en` read 1, and `cke_err` reads 0.
- R2: In normal state, an activate strobe sets bit `bank` of `open_banks`. A precharge strobe clears that bit, or clears every bit when `pre_all` is high. Read, write and auto refresh strobes leave the mask unchanged. Strobe bits are 0 activate, 1 precharge, 2 auto refresh, 3 read and 4 write.
- R3: In normal state, if `cke_reg` is low at a rising edge, no bank is open and no auto refresh strobe is present, the state becomes precharge power-down (`pd_state` = 1).
- R4: In normal state, if `cke_reg` is low at a rising edge and at least one bank is open, the state becomes active power-down (`pd_state` = 2). This holds even when an auto refresh strobe is present. Active power-down never moves directly to self refresh.
- R5: In normal state, if `cke_reg` is low at a rising edge, an auto refresh strobe is present and no bank is open, the state becomes self refresh (`pd_state` = 3).
- R6: In either power-down state, `in_rx_en` is 0 and `clk_rx_en` is 1. Commands are ignored there, so `open_banks` does not change.
- R7: In self refresh, `in_rx_en` is 0. `clk_rx_en` equals `cke_raw` with no clock edge involved. `cke_reg` has no effect. After `cke_raw` rises, the state returns to normal on the third rising edge.
- R8: Precharge or active power-down ends on the first rising edge that samples `cke_reg` high. `cke_raw` alone does not end it.
- R9: In normal state, if `cke_reg` is low at a rising edge while `burst_busy`, a read strobe or a write strobe is high, `cke_err` is 1 for the following cycle and the state stays normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cke_reg | input | 1 | Clock enable, registered copy |
| cke_raw | input | 1 | Clock enable, unclocked copy |
| cmd_strobe | input | 5 | One-hot command: 0 activate, 1 precharge, 2 auto refresh, 3 read, 4 write |
| bank | input | 2 | Bank address for activate and precharge |
| pre_all | input | 1 | With precharge, closes every bank |
| burst_busy | input | 1 | A read, write or snoop burst is in progress |
| pd_state | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self refresh |
| open_banks | output | 4 | Mask of open banks |
| in_rx_en | output | 1 | Enable for the input receivers other than clock and clock enable |
| clk_rx_en | output | 1 | Enable for the clock receivers |
| cke_err | output | 1 | Illegal clock-enable drop, one cycle per offence |

## Verification
The bench sweeps all sixteen open-bank masks. For each mask it lowers clock enable both with and without an auto refresh strobe. This separates the three power-down destinations and shows that auto refresh is refused whenever a bank is open. In each reached state the bench issues a precharge-all that must be ignored, then leaves by the matching path. For ordinary power-down, the unclocked clock enable is raised alone first and must change nothing. For self refresh, the registered copy is raised first and must change nothing, and the unclocked copy must open the clock receivers at once while the state waits three edges. Burst-busy, read and write are each paired with a clock-enable drop to show the error pulse and the refused entry.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [1:0] {
        PD_NORMAL = 2'd0,
        PD_PRE    = 2'd1,
        PD_ACT    = 2'd2,
        PD_SREF   = 2'd3
    } pd_state_e;

    localparam int CMD_W = 5;

    // Bit 0 is activate, bit 4 is write.
    typedef struct packed {
        logic wr;
        logic rd;
        logic refresh;
        logic pre;
        logic act;
    } cmd_s;

    function automatic logic moves_data(input cmd_s c, input logic busy);
        return busy | c.rd | c.wr;
    endfunction

    function automatic logic in_powerdown(input pd_state_e s);
        return (s == PD_PRE) || (s == PD_ACT);
    endfunction

endpackage

// File: rtl/pd_cke_sync.sv
module pd_cke_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pd_bank_tracker.sv
module pd_bank_tracker #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd_en,
    input  logic                 act,
    input  logic                 pre,
    input  logic                 pre_all,
    input  logic [BANK_W-1:0]    bank,
    output logic [NUM_BANKS-1:0] open_mask
);
    generate
        for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            logic hit;
            assign hit = (bank == BANK_W'(gb));
            always_ff @(posedge clk) begin
                if (rst) begin
                    open_mask[gb] <= 1'b0;
                end else if (upd_en) begin
                    if (act && hit)
                        open_mask[gb] <= 1'b1;
                    else if (pre && (pre_all || hit))
                        open_mask[gb] <= 1'b0;
                end
            end
        end
    endgenerate

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        upd_en && act |=> open_mask[$past(bank)]); // R2
    AST_PREALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        upd_en && pre && pre_all && !act |=> open_mask == '0); // R2
    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(open_mask)); // R6
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
    import pd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cke_reg,
    input  logic      cke_raw_s,
    input  logic      banks_open,
    input  logic      refresh,
    input  logic      data_move,
    output pd_state_e state_q,
    output logic      cke_err
);
    pd_state_e nxt;
    logic      armed_q;
    logic      illegal;

    assign illegal = (state_q == PD_NORMAL) && !cke_reg && data_move;

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            PD_NORMAL: begin
                if (!cke_reg && !illegal) begin
                    if (banks_open)   nxt = PD_ACT;
                    else if (refresh) nxt = PD_SREF;
                    else              nxt = PD_PRE;
                end
            end
            PD_PRE, PD_ACT: begin
                if (cke_reg) nxt = PD_NORMAL;
            end
            PD_SREF: begin
                if (armed_q && cke_raw_s) nxt = PD_NORMAL;
            end
            default: nxt = PD_NORMAL;
        endcase
    end

    // The synchronized copy must be seen low inside self refresh before it
    // may end it, so a stale high left in the chain at entry is ignored.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PD_NORMAL;
            armed_q <= 1'b0;
            cke_err <= 1'b0;
        end else begin
            state_q <= nxt;
            armed_q <= (state_q == PD_SREF) ? (armed_q | !cke_raw_s) : 1'b0;
            cke_err <= illegal;
        end
    end

    AST_OPEN_BLOCKS_SREF: assert property (@(posedge clk) disable iff (rst)
        (state_q != PD_SREF) && banks_open |=> state_q != PD_SREF); // R4
    AST_APD_NO_SREF: assert property (@(posedge clk) disable iff (rst)
        state_q == PD_ACT |=> state_q != PD_SREF); // R4
    AST_ERR_KEEPS_NORMAL: assert property (@(posedge clk) disable iff (rst)
        cke_err |-> state_q == PD_NORMAL); // R9
    AST_SREF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == PD_SREF) && !cke_raw_s |=> state_q == PD_SREF); // R7
    AST_PD_SYNC_EXIT: assert property (@(posedge clk) disable iff (rst)
        in_powerdown(state_q) && cke_reg |=> state_q == PD_NORMAL); // R8
endmodule

// File: rtl/dram_pwr_state_ctrl.sv
module dram_pwr_state_ctrl
    import pd_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke_reg,
    input  logic                 cke_raw,
    input  logic [CMD_W-1:0]     cmd_strobe,
    input  logic [BANK_W-1:0]    bank,
    input  logic                 pre_all,
    input  logic                 burst_busy,
    output logic [1:0]           pd_state,
    output logic [NUM_BANKS-1:0] open_banks,
    output logic                 in_rx_en,
    output logic                 clk_rx_en,
    output logic                 cke_err
);
    cmd_s      cmd;
    pd_state_e state;
    logic      cke_raw_s;
    logic      normal;

    assign cmd    = cmd_s'(cmd_strobe);
    assign normal = (state == PD_NORMAL);

    pd_cke_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cke_raw),
        .dout (cke_raw_s)
    );

    pd_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (normal),
        .act       (cmd.act),
        .pre       (cmd.pre),
        .pre_all   (pre_all),
        .bank      (bank),
        .open_mask (open_banks)
    );

    pd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cke_reg    (cke_reg),
        .cke_raw_s  (cke_raw_s),
        .banks_open (|open_banks),
        .refresh    (cmd.refresh),
        .data_move  (moves_data(cmd, burst_busy)),
        .state_q    (state),
        .cke_err    (cke_err)
    );

    assign pd_state  = state;
    assign in_rx_en  = normal;
    assign clk_rx_en = (state != PD_SREF) | cke_raw;

    AST_PD_RX_SPLIT: assert property (@(posedge clk) disable iff (rst)
        in_powerdown(pd_state_e'(pd_state)) |-> !in_rx_en && clk_rx_en); // R6
    AST_SREF_RX_OFF: assert property (@(posedge clk) disable iff (rst)
        (pd_state == 2'd3) |-> !in_rx_en && (clk_rx_en == cke_raw)); // R7
endmodule

// File: tb/dram_pwr_state_ctrl_tb.sv
module dram_pwr_state_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       cke_reg, cke_raw;
    logic [4:0] cmd_strobe;
    logic [1:0] bank;
    logic       pre_all, burst_busy;
    logic [1:0] pd_state;
    logic [3:0] open_banks;
    logic       in_rx_en, clk_rx_en, cke_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [4:0] C_ACT = 5'b00001, C_PRE = 5'b00010,
                           C_REF = 5'b00100, C_RD  = 5'b01000,
                           C_WR  = 5'b10000;

    dram_pwr_state_ctrl u_dut (
        .clk(clk), .rst(rst), .cke_reg(cke_reg), .cke_raw(cke_raw),
        .cmd_strobe(cmd_strobe), .bank(bank), .pre_all(pre_all),
        .burst_busy(burst_busy), .pd_state(pd_state), .open_banks(open_banks),
        .in_rx_en(in_rx_en), .clk_rx_en(clk_rx_en), .cke_err(cke_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic issue(input logic [4:0] c, input logic [1:0] b, input logic all);
        cmd_strobe = c; bank = b; pre_all = all;
        cyc();
        cmd_strobe = '0; pre_all = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cke_reg = 1'b1; cke_raw = 1'b1; cmd_strobe = '0;
        bank = '0; pre_all = 1'b0; burst_busy = 1'b0;
        cyc(); cyc();
        rst = 1'b0;
        // R1 reset state
        chk(pd_state == 0 && open_banks == 0 && in_rx_en && clk_rx_en && !cke_err,
            "R1", {pd_state, open_banks}, 0);

        // R2 single-bank precharge and data commands leave the mask alone
        issue(C_ACT, 2'd0, 1'b0);
        issue(C_ACT, 2'd2, 1'b0);
        chk(open_banks == 4'b0101, "R2", open_banks, 5);
        issue(C_PRE, 2'd2, 1'b0);
        chk(open_banks == 4'b0001, "R2", open_banks, 1);
        issue(C_RD, 2'd1, 1'b0);
        issue(C_WR, 2'd3, 1'b0);
        issue(C_REF, 2'd0, 1'b0);
        chk(open_banks == 4'b0001, "R2", open_banks, 1);
        issue(C_PRE, 2'd1, 1'b1);
        chk(open_banks == 4'b0000, "R2", open_banks, 0);

        // Sweep every open mask, with and without auto refresh at entry
        for (int m = 0; m < 16; m++) begin
            for (int r = 0; r < 2; r++) begin
                int exp;
                for (int b = 0; b < 4; b++)
                    if (m[b]) issue(C_ACT, 2'(b), 1'b0);
                chk(open_banks == 4'(m), "R2", open_banks, m);
                exp = (m != 0) ? 2 : (r != 0 ? 3 : 1);
                cke_reg = 1'b0; cke_raw = 1'b0;
                issue(r != 0 ? C_REF : 5'b0, 2'd0, 1'b0);
                chk(pd_state == 2'(exp), exp == 1 ? "R3" : (exp == 2 ? "R4" : "R5"),
                    pd_state, exp);
                chk(!in_rx_en && clk_rx_en == (exp != 3), "R6",
                    {in_rx_en, clk_rx_en}, exp != 3 ? 1 : 0);
                issue(C_PRE, 2'd0, 1'b1);
                chk(open_banks == 4'(m), "R6", open_banks, m);
                if (exp == 3) begin
                    cyc();
                    cke_reg = 1'b1;
                    cyc();
                    chk(pd_state == 3 && !clk_rx_en, "R7", pd_state, 3);
                    cke_raw = 1'b1;
                    #1;
                    chk(clk_rx_en && !in_rx_en, "R7", clk_rx_en, 1);
                    cyc(); cyc();
                    chk(pd_state == 3, "R7", pd_state, 3);
                    cyc();
                    chk(pd_state == 0 && in_rx_en, "R7", pd_state, 0);
                end else begin
                    cke_raw = 1'b1;
                    cyc(); cyc(); cyc();
                    chk(pd_state == 2'(exp), "R8", pd_state, exp);
                    cke_reg = 1'b1;
                    cyc();
                    chk(pd_state == 0 && in_rx_en, "R8", pd_state, 0);
                end
                issue(C_PRE, 2'd0, 1'b1);
                chk(open_banks == 0, "R2", open_banks, 0);
            end
        end

        // R9 clock-enable drop during data movement
        for (int k = 0; k < 3; k++) begin
            cke_reg = 1'b0; cke_raw = 1'b0;
            burst_busy = (k == 0);
            issue(k == 1 ? C_RD : (k == 2 ? C_WR : 5'b0), 2'd0, 1'b0);
            chk(cke_err && pd_state == 0, "R9", {cke_err, pd_state}, 4);
            burst_busy = 1'b0;
            cyc();
            chk(!cke_err && pd_state == 1, "R9", {cke_err, pd_state}, 1);
            cke_reg = 1'b1; cke_raw = 1'b1;
            cyc();
            chk(pd_state == 0, "R8", pd_state, 0);
        end

        // R1 reset out of a power-down state
        issue(C_ACT, 2'd3, 1'b0);
        cke_reg = 1'b0;
        cyc();
        rst = 1'b1; cke_reg = 1'b1;
        cyc();
        rst = 1'b0;
        chk(pd_state == 0 && open_banks == 0 && in_rx_en && clk_rx_en && !cke_err,
            "R1", {pd_state, open_banks}, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule